// File: doc/BRIEF.md
# PHY Control Port Handshake Responder

This block is the PHY-side end of an indirect register port. The host has no direct address space into the PHY. It drives a single 32-bit control word and polls a 32-bit status word. The responder watches four strobe bits in the control word: capture address, capture data, write and read. It reacts to each one by latching the 16-bit payload, committing a write, or presenting read data. It then acknowledges the step with a four-phase level handshake.

A complete register write takes three steps: capture the address, capture the data, then strobe the write. A read takes two steps: capture the address, then strobe the read. Each step finishes only after ack has risen and then fallen again. Ack rises a fixed, parameterised number of cycles after a strobe appears, which models the latency of the PHY clock domain. The host gives up after roughly ten polls, so this latency is kept to a few cycles. The PHY registers themselves are a small internal file of 16-bit words, cleared by reset.

Top module: `phy_ctl_responder`

## Requirements
- R1: Control word layout: payload in bits 15:0, capture-address strobe in bit 16, capture-data strobe in bit 17, write strobe in bit 18, read strobe in bit 19. Status word layout: ack in bit 16, read data in bits 15:0, bits 31:17 always zero.
- R2: After reset, ack is low, the status word is zero, and every register in the file reads back as zero.
- R3: When exactly one strobe is set in a control word driven while all strobes were clear, ack rises on the (ACK_DLY+2)-th rising clock edge after the word is applied.
- R4: Ack stays high while any strobe remains set. Once all strobes are clear, ack falls on the second rising edge after the clear.
- R5: A capture-address step latches payload bits 15:0 as the target register address.
- R6: A capture-data step latches payload bits 15:0 as the pending write data.
- R7: A write step stores the pending write data into the register at the latched address. A read step shows that register's value in status bits 15:0 while ack is high. Status bits 15:0 are zero whenever ack is low.
- R8: A control word with two or more strobe bits set together gives no ack and changes no latch or register. No ack follows until every strobe has been cleared.
- R9: If the strobe pattern changes to a different non-zero value before ack rises, the step is abandoned: no ack, and no latch or register update.
- R10: The latched address selects one of NUM_REGS registers. A write to an address at or above NUM_REGS changes nothing, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PHY-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word from the host: payload and four strobes |
| stat_o | output | 32 | Status word to the host: ack and read data |

## Verification
The assertions check the handshake shape on every cycle. Ack holds while a strobe is present and drops one cycle after the registered strobes clear. Ack rises only after a single strobe was present. Multiple strobes never lead to ack. Read data and the upper status bits stay zero outside ack. Only the bench scenarios can show the end-to-end effect of a step: that addresses and data are latched, that writes land in the right register, and that out-of-range addresses are inert. They also show that abandoned or multi-strobe steps leave all state unchanged, and that the latency is exact. These checks compare read-back values against a register model kept in the bench.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned NUM_STRB     = 4;
  localparam int unsigned STRB_LSB     = 16;
  localparam int unsigned ACK_BIT      = 16;
  localparam int unsigned CTRL_W       = 32;

  // op index equals strobe offset above STRB_LSB
  typedef enum logic [1:0] {
    OP_CAP_ADDR = 2'd0,
    OP_CAP_DATA = 2'd1,
    OP_WRITE    = 2'd2,
    OP_READ     = 2'd3
  } phy_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_ACK,
    ST_IGNORE
  } hs_state_e;
endpackage

// File: rtl/phy_strobe_in.sv
module phy_strobe_in
  import phy_port_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CTRL_W-1:0]   ctrl_i,
  output logic [NUM_STRB-1:0] strb_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                single_o,
  output logic                multi_o,
  output phy_op_e             op_o
);
  logic [NUM_STRB-1:0] strb_q;
  logic [DATA_W-1:0]   data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= '0;
      data_q <= '0;
    end else begin
      strb_q <= ctrl_i[STRB_LSB +: NUM_STRB];
      data_q <= ctrl_i[DATA_W-1:0];
    end
  end

  always_comb begin
    op_o = OP_CAP_ADDR;
    for (int i = 0; i < NUM_STRB; i++) begin
      if (strb_q[i]) op_o = phy_op_e'(i);
    end
  end

  assign single_o = (strb_q != '0) && ((strb_q & (strb_q - 1'b1)) == '0);
  assign multi_o  = (strb_q != '0) && !single_o;
  assign strb_o   = strb_q;
  assign data_o   = data_q;
endmodule

// File: rtl/phy_hs_fsm.sv
module phy_hs_fsm
  import phy_port_pkg::*;
#(
  parameter int unsigned ACK_DLY = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_STRB-1:0] strb_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                single_i,
  input  logic                multi_i,
  input  phy_op_e             op_i,
  output logic                ack_o,
  output logic                commit_o,
  output phy_op_e             commit_op_o,
  output logic [DATA_W-1:0]   commit_data_o
);
  localparam int unsigned CNT_W = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DLY - 1);

  hs_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_STRB-1:0] pat_q;
  phy_op_e             op_q;
  logic [DATA_W-1:0]   data_q;
  logic                take;

  assign take = (state_q == ST_IDLE) && single_i;

  always_comb begin
    state_d  = state_q;
    commit_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (single_i)     state_d = ST_DELAY;
        else if (multi_i) state_d = ST_IGNORE;
      end
      ST_DELAY: begin
        if (strb_i == '0)          state_d = ST_IDLE;
        else if (strb_i != pat_q)  state_d = ST_IGNORE;
        else if (cnt_q == CNT_LAST) begin
          state_d  = ST_ACK;
          commit_o = 1'b1;
        end
      end
      ST_ACK, ST_IGNORE: begin
        if (strb_i == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pat_q   <= '0;
      op_q    <= OP_CAP_ADDR;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        cnt_q  <= '0;
        pat_q  <= strb_i;
        op_q   <= op_i;
        data_q <= data_i;
      end else if (state_q == ST_DELAY && cnt_q != CNT_LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ack_o         = (state_q == ST_ACK);
  assign commit_op_o   = op_q;
  assign commit_data_o = data_q;
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  phy_op_e           op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS);

  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign in_range = 32'(addr_q) < NUM_REGS;
  assign idx      = addr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (commit_i) begin
      unique case (op_i)
        OP_CAP_ADDR: addr_q  <= data_i;
        OP_CAP_DATA: wdata_q <= data_i;
        OP_READ:     rdata_q <= in_range ? mem_q[idx] : '0;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (commit_i && op_i == OP_WRITE && in_range && 32'(idx) == g)
        mem_q[g] <= wdata_q;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/phy_ctl_responder.sv
module phy_ctl_responder
  import phy_port_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ACK_DLY  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ctrl_i,
  output logic [31:0] stat_o
);
  logic [NUM_STRB-1:0] strb_q;
  logic [DATA_W-1:0]   data_q;
  logic                single, multi, ack, commit;
  phy_op_e             op, commit_op;
  logic [DATA_W-1:0]   commit_data, rdata;

  phy_strobe_in u_in (
    .clk_i, .rst_ni, .ctrl_i,
    .strb_o(strb_q), .data_o(data_q),
    .single_o(single), .multi_o(multi), .op_o(op)
  );

  phy_hs_fsm #(.ACK_DLY(ACK_DLY)) u_fsm (
    .clk_i, .rst_ni,
    .strb_i(strb_q), .data_i(data_q),
    .single_i(single), .multi_i(multi), .op_i(op),
    .ack_o(ack), .commit_o(commit),
    .commit_op_o(commit_op), .commit_data_o(commit_data)
  );

  phy_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i, .rst_ni,
    .commit_i(commit), .op_i(commit_op), .data_i(commit_data),
    .rdata_o(rdata)
  );

  always_comb begin
    stat_o             = '0;
    stat_o[ACK_BIT]    = ack;
    stat_o[DATA_W-1:0] = ack ? rdata : '0;
  end
endmodule

// File: rtl/phy_ctl_responder_chk.sv
module phy_ctl_responder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  strb_i,
  input logic [31:0] stat_i
);
  p_status_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[31:17] == '0);

  p_rdata_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_i[16] |-> stat_i[15:0] == '0);

  p_ack_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[16] && strb_i != '0) |=> stat_i[16]);

  p_ack_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[16] && strb_i == '0) |=> !stat_i[16]);

  p_ack_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[16]) |-> $countones($past(strb_i)) == 1);

  p_multi_no_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_i[16] && $countones(strb_i) > 1) |=> !stat_i[16]);
endmodule

bind phy_ctl_responder phy_ctl_responder_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .strb_i (strb_q),
  .stat_i (stat_o)
);

// File: tb/tb_phy_ctl_responder.sv
module tb_phy_ctl_responder;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned ACK_DLY  = 3;
  localparam int B_CA = 16, B_CD = 17, B_WR = 18, B_RD = 19;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl = '0;
  logic [31:0] stat_o;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [15:0] model [NUM_REGS];

  always #4 clk = ~clk;

  phy_ctl_responder #(.NUM_REGS(NUM_REGS), .ACK_DLY(ACK_DLY)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl), .stat_o(stat_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    return (32'(a) < NUM_REGS) ? model[a[3:0]] : 16'h0;
  endfunction

  // one handshake step; checks R3 latency and R4 fall
  task automatic step(input int b, input logic [15:0] d, output logic [15:0] rd);
    int lat;
    int fall;
    ctrl = (32'h1 << b) | {16'h0, d};
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk); lat++;
      if (stat_o[16]) break;
    end
    chk(lat == ACK_DLY + 2, "R3 ack latency", lat, ACK_DLY + 2);
    rd = stat_o[15:0];
    @(posedge clk); @(negedge clk);
    chk(stat_o[16] == 1'b1, "R4 ack held while strobe set", stat_o[16], 1);
    ctrl = {16'h0, d};
    fall = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk); fall++;
      if (!stat_o[16]) break;
    end
    chk(fall == 2, "R4 ack fall", fall, 2);
    chk(stat_o[15:0] == 16'h0, "R7 data zero without ack", stat_o[15:0], 0);
  endtask

  task automatic phy_wr(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] rd;
    step(B_CA, a, rd);
    step(B_CD, d, rd);
    step(B_WR, 16'h0, rd);
    if (32'(a) < NUM_REGS) model[a[3:0]] = d;
  endtask

  task automatic phy_rd(input logic [15:0] a, input string req);
    logic [15:0] rd;
    step(B_CA, a, rd);
    step(B_RD, 16'h0, rd);
    chk(rd == exp_read(a), req, rd, exp_read(a));
  endtask

  // drives a pattern that must never be acknowledged
  task automatic no_ack(input logic [31:0] w, input string req);
    bit seen;
    seen = 1'b0;
    ctrl = w;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (stat_o[16]) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
    ctrl = '0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(stat_o == 32'h0, "R2 status after reset", stat_o, 0);
    for (int i = 0; i < NUM_REGS; i++) phy_rd(16'(i), "R2 reset register value");

    // R5 R6 R7 directed
    phy_wr(16'h0003, 16'hBEEF);
    phy_rd(16'h0003, "R7 read back after write");
    phy_wr(16'h000F, 16'h1234);
    phy_rd(16'h000F, "R5 last address latched");
    phy_rd(16'h0003, "R6 other register intact");

    // R1 status upper bits
    step(B_CA, 16'h0003, rd);
    ctrl = 32'h1 << B_RD;
    repeat (ACK_DLY + 2) begin @(posedge clk); @(negedge clk); end
    chk(stat_o == 32'h0001_BEEF, "R1 status layout", stat_o, 32'h0001_BEEF);
    ctrl = '0;
    repeat (3) begin @(posedge clk); @(negedge clk); end

    // R10 out of range
    phy_wr(16'(NUM_REGS), 16'hAAAA);
    phy_rd(16'(NUM_REGS), "R10 out-of-range read zero");
    phy_wr(16'hFFF0, 16'h5555);
    phy_rd(16'h0000, "R10 aliasing write ignored");

    // R8 multi-strobe: addr+write with new payload
    step(B_CA, 16'h0003, rd);
    step(B_CD, 16'h7777, rd);
    no_ack((32'h1 << B_CA) | (32'h1 << B_WR) | 32'h0005, "R8 multi strobe no ack");
    step(B_RD, 16'h0, rd);
    chk(rd == 16'hBEEF, "R8 no commit on multi strobe", rd, 16'hBEEF);
    step(B_WR, 16'h0, rd);
    model[3] = 16'h7777;
    phy_rd(16'h0003, "R8 latches untouched");

    // R9 abort: capture data then add write before ack
    ctrl = (32'h1 << B_CD) | 32'h0000_1111;
    @(posedge clk); @(negedge clk);
    no_ack((32'h1 << B_CD) | (32'h1 << B_WR) | 32'h1111, "R9 changed strobe no ack");
    step(B_WR, 16'h0, rd);
    phy_rd(16'h0003, "R9 pending data unchanged");

    // random traffic
    for (int n = 0; n < 60; n++) begin
      logic [15:0] a;
      a = 16'($urandom_range(0, NUM_REGS + 3));
      if ($urandom_range(0, 1) == 0) phy_wr(a, 16'($urandom));
      else phy_rd(a, "R7 random read");
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule